// File: doc/BRIEF.md
# Programmable Tone Square-Wave Generator

This block turns a fixed system clock into a symmetric square wave at a sub-audible signalling frequency or an audio frequency. A tone code is taken from the select inputs once, on the first clock after reset. It picks one of 64 built-in entries, and each entry holds three 8-bit divider presets. Each half period is timed by three byte counters that run in sequence. An outer coarse counter steps down. Between outer steps, an inner counter is reloaded and run to zero. Once the outer counter is exhausted, a fine counter runs to zero. The output level then inverts and the counters are reloaded.

An active-low push-to-talk input gates generation. While it is released, the current half period runs to completion and the block then parks with its output frozen. When push-to-talk is pressed, timing restarts from a freshly loaded counter set. A tick-enable input advances the counters. Driving it high on every clock gives the fastest tone. Pulsing it once every N clocks stretches every half period by N.

Top module: `tone_square_gen`

## Requirements
- R1: After reset `tone_out` is 0, and it stays 0 for as long as `ptt_n` is held high.
- R2: Only bits [5:0] of `tone_sel` form the tone code. Bits above bit 5 have no effect on the output period.
- R3: The tone code is captured on the first clock after reset is released. Later changes of `tone_sel` leave the output period unchanged until the next reset.
- R4: Each entry is three bytes {outer O, fine F, inner I}. One half period lasts T = O + (O-1)*I + F counter steps, where a step is one clock with `tick_en` high. This includes the case O = 1, where no inner count occurs. Entry values: code 0 = {02,01,9D}, so T = 160. Code 1 = {86,82,10}, so T = 2392. Code 54 = {01,84,9D}, so T = 133. Code 63 = {02,07,20}, so T = 41 (all values hex).
- R5: The high and low half periods are equal in length.
- R6: When `ptt_n` goes high during a half period, that half period completes and `tone_out` inverts once more. After that, `tone_out` holds its level and no further half period starts.
- R7: When `ptt_n` goes low while the block is parked, the counters are reloaded on the next clock. The next inversion of `tone_out` comes exactly T steps after that reload.
- R8: With `tick_en` high on one clock in every N, a half period lasts exactly N*T clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Counter step enable |
| ptt_n | input | 1 | Push-to-talk, active low |
| tone_sel | input | SEL_W | Tone select; bits [5:0] used, captured once after reset |
| tone_out | output | 1 | Square-wave tone output |

## Verification
A wrong value in any of the three counters, or a wrong preset read from the table, does not show at once. It appears only at the next inversion of `tone_out`, which then comes too early or too late. Such a fault is therefore visible within one half period, at most a few thousand steps. A fault in the inner reload shows as an error that is a multiple of the inner preset. A fault in the fine stage shows as a small constant offset. Measuring two successive half periods tells a timing fault apart from a high/low imbalance. A tone code that is captured twice, or taken from the wrong bits, shows as the half period of a different entry.

// File: rtl/tone_square_gen.sv
`timescale 1ns/1ps
module tone_square_gen #(
  parameter int SEL_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ptt_n,
  input  logic [SEL_W-1:0] tone_sel,
  output logic             tone_out
);
  localparam int CODE_W = 6;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_OUTER, S_INNER, S_FINE} state_t;

  state_t           state;
  logic             loaded;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] outer, inner, fine;
  logic [23:0]      entry;
  logic [CNT_W-1:0] p_outer, p_fine, p_inner;

  wire [CODE_W-1:0] code = sel_q[CODE_W-1:0];

  assign p_outer = entry[23:16];
  assign p_fine  = entry[15:8];
  assign p_inner = entry[7:0];

  always_comb begin
    entry = '0;
    case (code)
      6'd0:  entry = 24'h02019D; 6'd1:  entry = 24'h868210; 6'd2:  entry = 24'h818510; 6'd3:  entry = 24'h84800F;
      6'd4:  entry = 24'h7F850F; 6'd5:  entry = 24'h7B7C0F; 6'd6:  entry = 24'h76860F; 6'd7:  entry = 24'h72820F;
      6'd8:  entry = 24'h748F0E; 6'd9:  entry = 24'h639110; 6'd10: entry = 24'h5F9A10; 6'd11: entry = 24'h5B4711;
      6'd12: entry = 24'h558811; 6'd13: entry = 24'h564911; 6'd14: entry = 24'h096EB9; 6'd15: entry = 24'h0881C9;
      6'd16: entry = 24'h0A7198; 6'd17: entry = 24'h0B7683; 6'd18: entry = 24'h0ACA83; 6'd19: entry = 24'h0A9A83;
      6'd20: entry = 24'h09F183; 6'd21: entry = 24'h08939D; 6'd22: entry = 24'h0794B0; 6'd23: entry = 24'h077CAD;
      6'd24: entry = 24'h0785A5; 6'd25: entry = 24'h087B89; 6'd26: entry = 24'h088083; 6'd27: entry = 24'h07A290;
      6'd28: entry = 24'h084786; 6'd29: entry = 24'h076095; 6'd30: entry = 24'h088678; 6'd31: entry = 24'h079287;
      6'd32: entry = 24'h079085; 6'd33: entry = 24'h077D85; 6'd34: entry = 24'h095A66; 6'd35: entry = 24'h094866;
      6'd36: entry = 24'h079E78; 6'd37: entry = 24'h08BB60; 6'd38: entry = 24'h094C60; 6'd39: entry = 24'h089D60;
      6'd40: entry = 24'h092F60; 6'd41: entry = 24'h078270; 6'd42: entry = 24'h077670; 6'd43: entry = 24'h076670;
      6'd44: entry = 24'h076F6A; 6'd45: entry = 24'h06A370; 6'd46: entry = 24'h069870; 6'd47: entry = 24'h068A70;
      6'd48: entry = 24'h067270; 6'd49: entry = 24'h04C399; 6'd50: entry = 24'h04B999; 6'd51: entry = 24'h051C99;
      6'd52: entry = 24'h031520; 6'd53: entry = 24'h050F10; 6'd54: entry = 24'h01849D; 6'd55: entry = 24'h021330;
      6'd56: entry = 24'h032650; 6'd57: entry = 24'h030F50; 6'd58: entry = 24'h023F50; 6'd59: entry = 24'h033620;
      6'd60: entry = 24'h016820; 6'd61: entry = 24'h030920; 6'd62: entry = 24'h021A20; 6'd63: entry = 24'h020720;
      default: entry = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      loaded   <= 1'b0;
      sel_q    <= '0;
      outer    <= '0;
      inner    <= '0;
      fine     <= '0;
      tone_out <= 1'b0;
    end else begin
      if (!loaded) begin
        sel_q  <= tone_sel;
        loaded <= 1'b1;
      end
      case (state)
        S_IDLE: if (loaded && !ptt_n) begin
          outer <= p_outer;
          fine  <= p_fine;
          state <= S_OUTER;
        end
        S_OUTER: if (tick_en) begin
          outer <= outer - ONE;
          if (outer != ONE) begin
            inner <= p_inner;
            state <= S_INNER;
          end else begin
            state <= S_FINE;
          end
        end
        S_INNER: if (tick_en) begin
          inner <= inner - ONE;
          if (inner == ONE) state <= S_OUTER;
        end
        S_FINE: if (tick_en) begin
          fine <= fine - ONE;
          if (fine == ONE) begin
            tone_out <= ~tone_out;
            if (!ptt_n) begin
              outer <= p_outer;
              fine  <= p_fine;
              state <= S_OUTER;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tone_square_gen_chk.sv
`timescale 1ns/1ps
module tone_square_gen_chk #(
  parameter int SEL_W = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             ptt_n,
  input logic             tone_out,
  input logic [1:0]       state,
  input logic             loaded,
  input logic [SEL_W-1:0] sel_q,
  input logic [CNT_W-1:0] outer
);
  localparam logic [1:0] C_IDLE  = 2'd0;
  localparam logic [1:0] C_OUTER = 2'd1;
  localparam logic [1:0] C_INNER = 2'd2;
  localparam logic [1:0] C_FINE  = 2'd3;

  assert_low_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !tone_out);

  assert_code_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && $past(loaded)) |-> $stable(sel_q));

  assert_inner_needs_outer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_INNER) |-> (outer != '0));

  assert_parked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_IDLE && ptt_n) |=> (state == C_IDLE && $stable(tone_out)));

  assert_resume_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_IDLE && loaded && !ptt_n) |=> (state == C_OUTER));

  assert_toggle_on_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_out != $past(tone_out)) |-> ($past(tick_en) && $past(state) == C_FINE));
endmodule

bind tone_square_gen tone_square_gen_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ptt_n(ptt_n), .tone_out(tone_out),
  .state(state), .loaded(loaded), .sel_q(sel_q), .outer(outer)
);

// File: tb/test_tone_square_gen.sv
`timescale 1ns/1ps
module test_tone_square_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       ptt_n = 1'b1;
  logic [7:0] tone_sel = 8'd0;
  logic       tone_out;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  bit done = 0;

  tone_square_gen i_tone_square_gen (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ptt_n(ptt_n),
    .tone_sel(tone_sel), .tone_out(tone_out)
  );

  always #2 clk = ~clk;

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt + 1 >= tick_div) ? 0 : cnt + 1;
      tick_en = (cnt == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] sel, input logic ptt);
    rst_n = 1'b0;
    tone_sel = sel;
    ptt_n = ptt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_edge(input int maxc, output int n);
    logic prev = tone_out;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (tone_out != prev) return;
      if (n >= maxc) begin n = -1; return; end
    end
  endtask

  task automatic test_reset_R1();
    int n;
    do_reset(8'd0, 1'b1);
    check(tone_out == 1'b0, "R1 reset level", tone_out, 0);
    wait_edge(600, n);
    check(n == -1, "R1 no toggle with ptt released", n, -1);
  endtask

  task automatic test_period(input logic [7:0] sel, input int t, input string req);
    int n, h1, h2;
    do_reset(sel, 1'b0);
    wait_edge(3 * t * tick_div + 50, n);
    wait_edge(3 * t * tick_div + 50, h1);
    wait_edge(3 * t * tick_div + 50, h2);
    check(h1 == t * tick_div, req, h1, t * tick_div);
    check(h2 == h1, {req, " R5 symmetry"}, h2, h1);
  endtask

  task automatic test_latch_R3();
    int n;
    do_reset(8'd63, 1'b0);
    wait_edge(200, n);
    tone_sel = 8'd1;
    wait_edge(200, n);
    wait_edge(200, n);
    check(n == 41, "R3 select change after capture ignored", n, 41);
  endtask

  task automatic test_ptt_R6_R7();
    int n;
    do_reset(8'd0, 1'b0);
    wait_edge(500, n);
    ptt_n = 1'b1;
    wait_edge(500, n);
    check(n == 160, "R6 current half completes", n, 160);
    wait_edge(400, n);
    check(n == -1, "R6 output holds while released", n, -1);
    ptt_n = 1'b0;
    wait_edge(500, n);
    check(n == 161, "R7 resume from fresh reload", n, 161);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    test_reset_R1();
    test_period(8'd0, 160, "R4 code 0");
    test_period(8'd1, 2392, "R4 code 1");
    test_period(8'd54, 133, "R4 code 54 single outer step");
    test_period(8'd63, 41, "R4 code 63");
    test_period(8'hFF, 41, "R2 upper select bits ignored");
    test_latch_R3();
    test_ptt_R6_R7();
    tick_div = 3;
    test_period(8'd63, 41, "R8 step every 3 clocks");
    tick_div = 1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule